// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog countdown protected by a rotating key. Software programs it through one write-only control word that holds a 7-bit key, a run/stop command bit and an 8-bit reload count. When the last accepted word carried the run command, the watchdog is locked. A later write then takes effect only if its key is the bitwise inverse of the key that was accepted before it. Any other write is dropped without a trace. A program that has lost control and keeps writing the same word therefore cannot keep the watchdog alive or turn it off.

An accepted write always reloads the count, where a count field of zero means 256. The command bit then either starts the countdown or halts it. The countdown drops by one on each pulse of a slow tick enable, which a prescaler outside the block drives at about 760 Hz. When the count reaches zero the block raises a one-cycle system reset request and stops. The current count, the running flag and the lock state are visible on status outputs.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, `cur_count` is 0, `armed` is 0, `locked` is 0 and `rst_req` is 0.
- R2: While `locked` is 0, every write is accepted whatever its key. The control word holds the key in bits [15:9], the command in bit 8 and the count in bits [7:0].
- R3: While `locked` is 1, a write whose key is not the 7-bit bitwise inverse of the stored key is discarded. `cur_count`, `armed` and `locked` keep their values, and so does the key expected next.
- R4: While `locked` is 1, a write whose key is the inverse of the stored key is accepted, and its key becomes the stored key. Feeding the watchdog therefore needs keys that alternate between a value and its inverse.
- R5: Every accepted write loads `cur_count` with its count field. A field of 0 loads 256.
- R6: An accepted write with command 1 sets `armed`. One with command 0 clears `armed`, and the count is then frozen at the loaded value.
- R7: While `armed` is 1, each cycle with `tick_en` high lowers `cur_count` by one. Without `tick_en`, or while `armed` is 0, the count holds.
- R8: The tick that takes the count from 1 to 0 makes `rst_req` high for exactly one cycle, in the same cycle that `cur_count` shows 0 and `armed` drops.
- R9: If an accepted write and a tick arrive in the same cycle, the write wins. The count takes the reload value and the tick is lost.
- R10: `locked` equals the command bit of the last accepted write. After the watchdog is stopped with the correct key, the next write is accepted whatever its key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 16 | Control word: key [15:9], command [8], count [7:0] |
| tick_en | input | 1 | Slow countdown tick enable |
| rst_req | output | 1 | One-cycle system reset request on expiry |
| cur_count | output | 9 | Current countdown value |
| armed | output | 1 | Countdown running |
| locked | output | 1 | Key check active |

## Verification
A stored key that is wrong, or not inverted when it should be, shows up on the very next write. A correctly keyed feed is refused, so `cur_count` keeps counting down where it should have reloaded. A bad reload path or a bad zero-to-256 mapping shows up one cycle after the write as a wrong `cur_count`. A countdown that is off by one moves `rst_req` a whole tick early or late. The bench counts ticks up to the expected expiry for every possible count field. At the tick one before expiry it checks that the request is still low, and after the last tick it checks that the request is high.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  // countdown state of the watchdog
  typedef enum logic {WD_IDLE = 1'b0, WD_COUNTING = 1'b1} wd_state_e;
  // value of the command bit that starts the countdown
  localparam logic KWD_CMD_RUN = 1'b1;
endpackage

// File: rtl/kwd_keycheck.sv
module kwd_keycheck #(
  parameter int KEY_W = 7
) (
  input  logic             wr_en,
  input  logic [KEY_W-1:0] new_key,
  input  logic [KEY_W-1:0] stored_key,
  input  logic             locked,
  output logic             accept,
  output logic             key_ok
);
  // key that the next write has to present while locked
  function automatic logic [KEY_W-1:0] expected_key(input logic [KEY_W-1:0] prev);
    return ~prev;
  endfunction

  always_comb begin
    key_ok = (new_key == expected_key(stored_key));
    accept = wr_en && (!locked || key_ok);
  end
endmodule

// File: rtl/kwd_ctrlreg.sv
module kwd_ctrlreg #(
  parameter int KEY_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [KEY_W-1:0] new_key,
  input  logic             new_cmd,
  output logic [KEY_W-1:0] stored_key,
  output logic             locked
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stored_key <= '0;
      locked     <= 1'b0;
    end else if (accept) begin
      stored_key <= new_key;
      locked     <= new_cmd;
    end
  end
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter
  import kwd_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic           load_run,
  input  logic           tick_en,
  output logic [CNT_W:0] count,
  output logic           running,
  output logic           expire,
  output logic           rst_req
);
  localparam int VW = CNT_W + 1;
  localparam logic [VW-1:0] FULL = VW'(1) << CNT_W;
  localparam logic [VW-1:0] ONE  = VW'(1);

  // a zero count field stands for the full range
  function automatic logic [VW-1:0] reload_of(input logic [CNT_W-1:0] f);
    return (f == '0) ? FULL : {1'b0, f};
  endfunction

  wd_state_e state;
  logic      step;

  always_comb begin
    running = (state == WD_COUNTING);
    step    = running && tick_en && !load;
    expire  = step && (count == ONE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      state   <= WD_IDLE;
      rst_req <= 1'b0;
    end else begin
      rst_req <= expire;
      if (load) begin
        count <= reload_of(load_cnt);
        state <= (load_run == KWD_CMD_RUN) ? WD_COUNTING : WD_IDLE;
      end else if (step) begin
        count <= count - ONE;
        if (count == ONE) state <= WD_IDLE;
      end
    end
  end

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == reload_of($past(load_cnt)))); // R5
  AST_RUN_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (running == $past(load_run))); // R6
  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick_en && !load && count > ONE) |=> (count == $past(count) - ONE)); // R7
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !load) |=> $stable(count)); // R7
  AST_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (rst_req && !running && count == '0)); // R8
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R8
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog #(
  parameter int KEY_W = 7,
  parameter int CNT_W = 8,
  localparam int DW = KEY_W + 1 + CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          tick_en,
  output logic          rst_req,
  output logic [CNT_W:0] cur_count,
  output logic          armed,
  output logic          locked
);
  localparam int CMD_BIT = CNT_W;
  localparam int KEY_LSB = CNT_W + 1;

  logic [KEY_W-1:0] new_key, stored_key;
  logic             new_cmd, accept, key_ok, expire;
  logic [CNT_W-1:0] new_cnt;

  assign new_key = wr_data[KEY_LSB +: KEY_W];
  assign new_cmd = wr_data[CMD_BIT];
  assign new_cnt = wr_data[CNT_W-1:0];

  kwd_keycheck #(.KEY_W(KEY_W)) u_key (
    .wr_en(wr_en), .new_key(new_key), .stored_key(stored_key),
    .locked(locked), .accept(accept), .key_ok(key_ok)
  );

  kwd_ctrlreg #(.KEY_W(KEY_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .accept(accept), .new_key(new_key),
    .new_cmd(new_cmd), .stored_key(stored_key), .locked(locked)
  );

  kwd_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_cnt(new_cnt),
    .load_run(new_cmd), .tick_en(tick_en), .count(cur_count),
    .running(armed), .expire(expire), .rst_req(rst_req)
  );

  AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && wr_en && !key_ok && !tick_en) |=> ($stable(cur_count) && $stable(armed) && $stable(locked))); // R3
  AST_REPEAT_KEY_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && wr_en && new_key == stored_key) |=> $stable(stored_key)); // R3
  AST_FREE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && wr_en) |=> (stored_key == $past(new_key) && locked == $past(new_cmd))); // R2
  AST_LOCK_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && key_ok) |=> (locked == $past(new_cmd))); // R10
  AST_FIRE_ONLY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(armed)); // R8
endmodule

// File: tb/sim_keyed_wdog.sv
`timescale 1ns/1ps
module sim_keyed_wdog;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        tick_en = 1'b0;
  logic        rst_req, armed, locked;
  logic [8:0]  cur_count;

  int checks = 0;
  int fails = 0;
  logic [6:0] exp_key = '0;
  logic       exp_lock = 1'b0;

  always #2.5 clk = ~clk;

  keyed_wdog u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .tick_en(tick_en), .rst_req(rst_req), .cur_count(cur_count),
    .armed(armed), .locked(locked)
  );

  function automatic int reload(input int f);
    return (f == 0) ? 256 : f;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one write, optionally with a tick in the same cycle
  task automatic wr(input logic [6:0] k, input logic c, input logic [7:0] n, input logic t);
    @(negedge clk);
    wr_en = 1'b1; wr_data = {k, c, n}; tick_en = t;
    @(negedge clk);
    wr_en = 1'b0; tick_en = 1'b0;
    if (!exp_lock || k == ~exp_key) begin
      exp_key = k; exp_lock = c;
    end
  endtask

  task automatic tick();
    @(negedge clk); tick_en = 1'b1;
    @(negedge clk); tick_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #900000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    // R1 reset state
    chk("R1 count", int'(cur_count), 0);
    chk("R1 armed", int'(armed), 0);
    chk("R1 locked", int'(locked), 0);
    chk("R1 rst_req", int'(rst_req), 0);
    rst_n = 1'b1;
    idle(1);

    // R2 / R6 unlocked write with arbitrary key, stop command
    wr(7'h2A, 1'b0, 8'd5, 1'b0);
    chk("R2 count", int'(cur_count), 5);
    chk("R6 armed", int'(armed), 0);
    tick();
    chk("R7 stopped holds", int'(cur_count), 5);
    // R2 / R5 / R10 start with another arbitrary key
    wr(7'h11, 1'b1, 8'd10, 1'b0);
    chk("R5 count", int'(cur_count), 10);
    chk("R6 armed", int'(armed), 1);
    chk("R10 locked", int'(locked), 1);

    // R3 sweep every wrong key
    for (int k = 0; k < 128; k++) begin
      if (7'(k) != ~exp_key) begin
        wr(7'(k), 1'b0, 8'd3, 1'b0);
        checks++;
        if (cur_count != 9'd10 || armed !== 1'b1 || locked !== 1'b1) begin
          fails++;
          $display("FAIL R3 key %0d: actual %0d/%0d/%0d expected 10/1/1",
                   k, cur_count, armed, locked);
        end
      end
    end

    // R4 alternating feeds, ticks between
    for (int i = 0; i < 4; i++) begin
      wr(~exp_key, 1'b1, 8'(20 + i), 1'b0);
      chk("R4 feed", int'(cur_count), 20 + i);
      tick();
      chk("R7 tick", int'(cur_count), 19 + i);
      wr(exp_key ^ 7'h01, 1'b1, 8'd2, 1'b0);
      chk("R4 noncomplement dropped", int'(cur_count), 19 + i);
    end
    // R4 repeating the last accepted key fails
    wr(exp_key, 1'b1, 8'd50, 1'b0);
    chk("R4 repeat key", int'(cur_count), 22);

    // R7 idle cycles without tick hold the count
    idle(5);
    chk("R7 no tick", int'(cur_count), 22);
    tick(); tick(); tick();
    chk("R7 three ticks", int'(cur_count), 19);

    // R9 write and tick together
    wr(~exp_key, 1'b1, 8'd40, 1'b1);
    chk("R9 write wins", int'(cur_count), 40);

    // R6 / R10 stop with correct key
    wr(~exp_key, 1'b0, 8'd9, 1'b0);
    chk("R6 stop armed", int'(armed), 0);
    chk("R6 stop count", int'(cur_count), 9);
    chk("R10 unlock", int'(locked), 0);
    tick();
    chk("R7 no count when stopped", int'(cur_count), 9);
    wr(exp_key, 1'b0, 8'd7, 1'b0);
    chk("R10 any key after stop", int'(cur_count), 7);

    // R5 / R8 expiry for every count field
    for (int c = 0; c < 256; c++) begin
      int n;
      n = reload(c);
      wr(exp_lock ? ~exp_key : 7'(c), 1'b1, 8'(c), 1'b0);
      chk("R5 reload", int'(cur_count), n);
      for (int j = 0; j < n - 1; j++) tick();
      checks++;
      if (cur_count != 9'd1 || rst_req !== 1'b0) begin
        fails++;
        $display("FAIL R8 pre-expiry c=%0d: actual %0d/%0d expected 1/0", c, cur_count, rst_req);
      end
      tick();
      checks++;
      if (rst_req !== 1'b1 || cur_count != 9'd0 || armed !== 1'b0) begin
        fails++;
        $display("FAIL R8 expiry c=%0d: actual %0d/%0d/%0d expected 1/0/0", c, rst_req, cur_count, armed);
      end
      idle(1);
      chk("R8 single pulse", int'(rst_req), 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule